// File: doc/BRIEF.md
# Tear-Free Split-Read Event Counter

This block holds a 32-bit count that advances by one on every clock cycle in which its enable input is high. A 16-bit register bus reads it in two accesses. Selecting the low half with the read strobe returns the low 16 bits of the count. On that same clock edge, the block copies the upper 16 bits into a holding register. A read of the upper half then returns the held copy. The two halves therefore always belong to the same count value, even when a carry ripples into the upper half between the two accesses.

Firmware can load any 32-bit value. It first writes the low half, which is only staged, and then writes the upper half. The upper-half write commits both halves together on one edge. Reset places the count at a configurable start value, which need not be zero. Counting never pauses for a bus access. Only the value handed to the bus is held.

Top module: `split_read_counter`

## Requirements
- R1: While reset is high, bus_rdata becomes 0, the count becomes START_VAL and the holding register becomes START_VAL[31:16]. All of these take effect on the clock edge.
- R2: On each edge where en is high and no upper-half write is present, the count goes up by exactly one. When en is low and no upper-half write is present, the count holds.
- R3: The count wraps from 32'hFFFF_FFFF to 32'h0000_0000 with no other effect.
- R4: A read with addr = 0 (low half) puts the count's bits 15:0, as they stood at that edge, on bus_rdata from the next cycle. On the same edge it copies the count's bits 31:16 into the holding register.
- R5: A read with addr = 1 (upper half) puts the holding register on bus_rdata from the next cycle, not the live upper bits.
- R6: A read with addr = 1 that follows no low-half read returns the value captured by the most recent low-half read. If there has been no low-half read since reset, it returns START_VAL[31:16]. Only a low-half read changes the holding register.
- R7: The count keeps advancing between and during the two reads of a pair.
- R8: A write with addr = 0 only stages bus_wdata and leaves the count unchanged.
- R9: A write with addr = 1 sets the count to {bus_wdata, staged low half} on that edge, taking priority over the increment. Counting resumes from the loaded value on the following edge.
- R10: bus_rdata holds its value on every edge without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable, one step per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | Half select: 0 low, 1 upper |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |

## Verification
The bench loads values that sit a few counts below a low-half carry and reads them back as split pairs while the count keeps running. Some pairs have idle gaps between the two reads. A design that returned live upper bits would show an upper half one too high after the carry. One that paused the count during reads would show a later low value that falls short. Loads just below all-ones force the wrap, which an overflow or saturation bug would break. The bench also checks the following:
- Upper-half reads made without a preceding low read, which would return the fresh value if the holding register tracked loads.
- Low-half writes that must not disturb the count.
- The read data register keeping its value across idle and write cycles.

// File: rtl/src_pkg.sv
package src_pkg;

    localparam int unsigned DEF_BUS_W = 16;

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;

    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_STEP = 2'd1,
        CNT_LOAD = 2'd2
    } cnt_op_e;

    typedef struct packed {
        logic rd_lo;
        logic rd_hi;
        logic wr_lo;
        logic wr_hi;
    } bus_strobe_t;

    // Commit of a firmware load wins over the increment.
    function automatic cnt_op_e pick_op(input logic load, input logic en);
        if (load)
            return CNT_LOAD;
        else if (en)
            return CNT_STEP;
        else
            return CNT_HOLD;
    endfunction

endpackage

// File: rtl/src_decode.sv
module src_decode
    import src_pkg::*;
(
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic        bus_addr,
    output bus_strobe_t strobe
);
    half_e half;

    always_comb begin
        half         = half_e'(bus_addr);
        strobe.rd_lo = bus_rd && (half == HALF_LO);
        strobe.rd_hi = bus_rd && (half == HALF_HI);
        strobe.wr_lo = bus_wr && (half == HALF_LO);
        strobe.wr_hi = bus_wr && (half == HALF_HI);
    end
endmodule

// File: rtl/src_core.sv
module src_core
    import src_pkg::*;
#(
    parameter int unsigned            CNT_W     = 32,
    parameter logic [CNT_W-1:0]       START_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count
);
    cnt_op_e          op;
    logic [CNT_W-1:0] count_d;

    always_comb begin
        op = pick_op(load, en);
        unique case (op)
            CNT_LOAD: count_d = load_val;
            CNT_STEP: count_d = count + CNT_W'(1);   // natural wrap at all-ones
            default:  count_d = count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            count <= START_VAL;
        else
            count <= count_d;
    end
endmodule

// File: rtl/src_shadow.sv
module src_shadow #(
    parameter int unsigned        BUS_W      = 16,
    parameter logic [BUS_W-1:0]   SHADOW_RST = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [BUS_W-1:0] cnt_upper,
    input  logic             stage_wr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] held_upper,
    output logic [BUS_W-1:0] staged_lower
);
    // Upper half frozen by a low-half read.
    always_ff @(posedge clk) begin
        if (rst)
            held_upper <= SHADOW_RST;
        else if (capture)
            held_upper <= cnt_upper;
    end

    // Low half of a pending firmware load.
    always_ff @(posedge clk) begin
        if (rst)
            staged_lower <= '0;
        else if (stage_wr)
            staged_lower <= wdata;
    end
endmodule

// File: rtl/src_rport.sv
module src_rport #(
    parameter int unsigned BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_lo,
    input  logic             rd_hi,
    input  logic [BUS_W-1:0] live_lower,
    input  logic [BUS_W-1:0] held_upper,
    output logic [BUS_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_lo)
            rdata <= live_lower;
        else if (rd_hi)
            rdata <= held_upper;
    end
endmodule

// File: rtl/split_read_counter.sv
module split_read_counter
    import src_pkg::*;
#(
    parameter int unsigned              BUS_W     = DEF_BUS_W,
    parameter logic [2*BUS_W-1:0]       START_VAL = 32'h0000_0001
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata
);
    localparam int unsigned CNT_W = 2 * BUS_W;

    bus_strobe_t      strobe;
    logic [CNT_W-1:0] cnt_q;
    logic [BUS_W-1:0] shadow_q;
    logic [BUS_W-1:0] stage_q;
    logic [CNT_W-1:0] load_val;

    assign load_val = {bus_wdata, stage_q};

    src_decode u_decode (
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .strobe   (strobe)
    );

    src_core #(
        .CNT_W     (CNT_W),
        .START_VAL (START_VAL)
    ) u_core (
        .clk      (clk),
        .rst      (rst),
        .en       (cnt_en),
        .load     (strobe.wr_hi),
        .load_val (load_val),
        .count    (cnt_q)
    );

    src_shadow #(
        .BUS_W      (BUS_W),
        .SHADOW_RST (START_VAL[CNT_W-1:BUS_W])
    ) u_shadow (
        .clk          (clk),
        .rst          (rst),
        .capture      (strobe.rd_lo),
        .cnt_upper    (cnt_q[CNT_W-1:BUS_W]),
        .stage_wr     (strobe.wr_lo),
        .wdata        (bus_wdata),
        .held_upper   (shadow_q),
        .staged_lower (stage_q)
    );

    src_rport #(
        .BUS_W (BUS_W)
    ) u_rport (
        .clk        (clk),
        .rst        (rst),
        .rd_lo      (strobe.rd_lo),
        .rd_hi      (strobe.rd_hi),
        .live_lower (cnt_q[BUS_W-1:0]),
        .held_upper (shadow_q),
        .rdata      (bus_rdata)
    );
endmodule

// File: rtl/src_checker.sv
module src_checker #(
    parameter int unsigned BUS_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               cnt_en,
    input logic               bus_rd,
    input logic               bus_wr,
    input logic               bus_addr,
    input logic [BUS_W-1:0]   bus_wdata,
    input logic [BUS_W-1:0]   bus_rdata,
    input logic [BUS_W-1:0]   shadow,
    input logic [2*BUS_W-1:0] cnt
);
    localparam int unsigned CW = 2 * BUS_W;

    a_r1_rdata_cleared: assert property (@(posedge clk)
        rst |=> (bus_rdata == '0));

    a_r2_count_holds: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !(bus_wr && bus_addr)) |=> (cnt == $past(cnt)));

    // also covers R3: the increment wraps modulo 2**CW
    a_r2_count_steps: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !(bus_wr && bus_addr)) |=> (cnt == $past(cnt) + CW'(1)));

    a_r9_upper_commit: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr) |=> (cnt[CW-1:BUS_W] == $past(bus_wdata)));

    a_r4_low_capture: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_addr) |=> ((bus_rdata == $past(cnt[BUS_W-1:0]))
                                   && (shadow == $past(cnt[CW-1:BUS_W]))));

    a_r5_upper_from_shadow: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr) |=> (bus_rdata == $past(shadow)));

    a_r6_shadow_kept: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && !bus_addr) |=> $stable(shadow));

    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind split_read_counter src_checker #(.BUS_W(BUS_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cnt_en    (cnt_en),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .shadow    (shadow_q),
    .cnt       (cnt_q)
);

// File: tb/split_read_counter_bench.sv
module split_read_counter_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_addr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    split_read_counter u_split_read_counter (
        .clk       (clk),
        .rst       (rst),
        .cnt_en    (cnt_en),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a negedge; one bus cycle; returns at the following negedge.
    task automatic op(input logic r, input logic w, input logic a, input logic [15:0] d);
        bus_rd = r; bus_wr = w; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: read data cleared by reset
        chk("R1 rdata after reset", bus_rdata, 16'h0000);
        // R6/R1: upper read before any low read gives START_VAL upper half
        op(1, 0, 1, '0);
        chk("R6 upper before low read", bus_rdata, 16'h0000);
        op(1, 0, 0, '0);
        chk("R1 start value low half", bus_rdata, 16'h0001);
        idle(3);
        op(1, 0, 0, '0);
        chk("R2 hold with enable low", bus_rdata, 16'h0001);

        // R10: idle and write cycles leave rdata alone
        op(0, 1, 0, 16'hBEEF);
        chk("R10 rdata held over low write", bus_rdata, 16'h0001);
        op(0, 1, 1, 16'hCAFE);
        chk("R10 rdata held over upper write", bus_rdata, 16'h0001);
        // R6: upper read with no low read returns the last capture, not the load
        op(1, 0, 1, '0);
        chk("R6 stale shadow after load", bus_rdata, 16'h0000);
        op(1, 0, 0, '0);
        chk("R9 loaded low half", bus_rdata, 16'hBEEF);
        op(1, 0, 1, '0);
        chk("R9 loaded upper half", bus_rdata, 16'hCAFE);

        // R8: staging a low half does not touch the count
        op(0, 1, 0, 16'h1111);
        op(1, 0, 0, '0);
        chk("R8 low write only staged", bus_rdata, 16'hBEEF);
        op(1, 0, 1, '0);
        chk("R8 upper unchanged", bus_rdata, 16'hCAFE);

        // R2: ten steps, the first read captures the value before them
        cnt_en = 1'b1;
        op(1, 0, 0, '0);
        chk("R2 first sample", bus_rdata, 16'hBEEF);
        idle(9);
        op(1, 0, 0, '0);
        chk("R2 ten steps later", bus_rdata, 16'hBEF9);

        // Sweep loads just below a carry, reading split pairs while counting.
        for (int h = 0; h < 3; h++) begin
            for (int k = 0; k < 8; k++) begin
                logic [15:0] hi;
                logic [31:0] v, v2, v9;
                hi = (h == 0) ? 16'h0000 : (h == 1) ? 16'h1234 : 16'hFFFF;
                v  = {hi, 16'hFFF8 + 16'(k)};
                v2 = v + 32'd2;
                v9 = v + 32'd9;
                op(0, 1, 0, v[15:0]);
                op(0, 1, 1, v[31:16]);                 // load edge, wins over step
                op(1, 0, 0, '0);
                chk("R9 load beats step, low", bus_rdata, v[15:0]);
                op(1, 0, 1, '0);
                chk("R5 pair upper", bus_rdata, v[31:16]);
                op(1, 0, 0, '0);
                chk("R7 low after two steps", bus_rdata, v2[15:0]);
                idle(5);
                op(1, 0, 1, '0);
                chk("R5 upper frozen across carry", bus_rdata, v2[31:16]);
                op(1, 0, 0, '0);
                chk("R7 counting kept on", bus_rdata, v9[15:0]);
                op(1, 0, 1, '0);
                if (v9 < v)
                    chk("R3 wrap to zero upper", bus_rdata, v9[31:16]);
                else
                    chk("R4 capture matches low", bus_rdata, v9[31:16]);
            end
        end
        cnt_en = 1'b0;
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end
endmodule